// File: doc/BRIEF.md
# BCD Clock Calendar with Frozen-View Transfer Buffer

This block keeps time of day and calendar date in packed BCD, from hundredths of a second up to a two-digit year. Two copies of the time exist. The internal copy advances on every 100 Hz enable tick while the oscillator runs. The user copy is what the register port reads. During normal running, the hundredths field of the user copy is refreshed on every tick. The fields from seconds up are copied across only when hundredths roll from 99 to 00. The internal seconds-to-years fields are advanced one tick earlier, on the 98-to-99 step, so they are already settled by then.

Software can clear a transfer-enable control to freeze the user copy. This gives a coherent snapshot, and the internal count keeps running meanwhile. Time fields written while frozen are recorded per field. When transfer enable is set again, only those fields are loaded into the internal counters, so the unwritten fields keep their accumulated time. A control bit in the month register starts or stops the oscillator. A second bit in the same register gates a 1024 Hz square wave, which is produced by toggling on a 2048 Hz enable tick.

Top module: `bcd_rtc_core`

## Requirements
- R1: Hundredths count 00..99, and seconds and minutes count 00..59, in BCD. When the counter stands at xx:59:59.99, one tick makes the visible value xx+1:00:00.00.
- R2: With hour bit 6 = 0 (24-hour mode), hours count 00..23. The step from 23 to 00 advances the day of week and the date.
- R3: With hour bit 6 = 1 (12-hour mode), bit 5 = 1 means PM and bits 4:0 hold 01..12 in BCD. 11 goes to 12 and flips bit 5. 12 goes to 01. The date and the day of week advance only on the step from 11 PM to 12 AM.
- R4: The day of week wraps from 07 to 01. The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other long months, and for month 02 either 29 when the binary year value is a multiple of 4 (00 included) or 28 otherwise. The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R5: While transfer is enabled, each tick refreshes visible hundredths. The visible seconds and higher fields change only on the tick where hundredths go from 99 to 00.
- R6: Transfer enable is bit 7 of address 0xB and resets to 1. Writing 0 freezes every visible time field while the internal time keeps counting. After it is set back to 1, hundredths resume on the next tick with no time lost, and the upper fields catch up at the next 99-to-00 rollover.
- R7: A time field written while transfer is disabled shows its new value at once. That value is loaded into the internal counter when transfer enable is written back to 1. Fields not written keep the internal running value.
- R8: Month register bit 7 = 1 stops the oscillator and resets to 1. While it is 1, the 100 Hz and 2048 Hz ticks have no effect on time or on the square wave.
- R9: Month register bit 6 = 0 drives `sqw_oe` high, and `sqw_out` then toggles on every 2048 Hz tick while the oscillator runs. Bit 6 = 1, which is the reset value, drives `sqw_oe` low and holds `sqw_out` at 0.
- R10: The register map is: 0x0 hundredths, 0x1 seconds, 0x2 minutes, 0x4 hours, 0x6 day of week, 0x8 date, 0x9 month, 0xA year, 0xB control. Unused bits read 0 whatever is written. Seconds, minutes and hours keep bits 6:0, day of week keeps 2:0, date keeps 5:0, month keeps bits 7, 6 and 4:0, and control keeps bit 7. All other addresses read 0 and ignore writes.
- R11: After reset the registers read hundredths 00, seconds 00, minutes 00, hours 00 (24-hour mode), day 01, date 01, month 0xC1, year 00 and control 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle enable that marks each 0.01 s |
| tick_2048hz | input | 1 | One-cycle enable for each square-wave half period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| sqw_out | output | 1 | 1024 Hz square wave |
| sqw_oe | output | 1 | Square-wave output enable |

## Verification
A table of start times is preloaded at 59 minutes, 59 seconds and 98 hundredths, then ticked twice. The hour, date, month and year values in the table separate a plain hour carry from 24-hour and 12-hour wraps. They also separate 30-day, 31-day and February ends, leap years from common years, and the year 00 case. The check after the first of the two ticks tells a design that refreshes the upper fields only at rollover from one that leaks the early internal increment. Directed sequences freeze and release transfer with and without writes in between. These show whether time is lost, and whether unwritten fields are wrongly reloaded from the stale view. Further sequences cover the oscillator stop, the square-wave gate and masked write-back.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_100hz,
  input  logic       tick_2048hz,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sqw_out,
  output logic       sqw_oe
);
  localparam logic [3:0] A_HUN = 4'h0, A_SEC = 4'h1, A_MIN = 4'h2, A_HR = 4'h4,
                         A_DOW = 4'h6, A_DAT = 4'h8, A_MON = 4'h9, A_YR = 4'hA,
                         A_CTL = 4'hB;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h1;
  endfunction

  logic [7:0] i_h, i_yr, u_h, u_yr;
  logic [6:0] i_s, i_m, i_hr, u_s, u_m, u_hr;
  logic [2:0] i_dw, u_dw;
  logic [5:0] i_dt, u_dt;
  logic [4:0] i_mo, u_mo;
  logic       te, osc_stop, sqw_dis, sqw_q;
  logic [7:0] dirty;

  logic run, pre, roll, load, wt;
  assign run  = tick_100hz & ~osc_stop;
  assign pre  = (i_h == 8'h98);
  assign roll = (i_h == 8'h99);
  assign load = wr_en & (addr == A_CTL) & wr_data[7] & ~te;
  assign wt   = wr_en & te;

  logic [7:0] n_h, n_yr, t8;
  logic [6:0] n_s, n_m, n_hr;
  logic [2:0] n_dw;
  logic [5:0] n_dt, dim;
  logic [4:0] n_mo;
  logic       c_s, c_m, c_hr, c_dt, c_mo, leap;
  logic [7:0] yr_bin;

  always_comb begin
    n_h  = roll ? 8'h00 : bcd_inc(i_h);
    c_s  = (i_s == 7'h59);
    t8   = bcd_inc({1'b0, i_s});
    n_s  = c_s ? 7'h00 : t8[6:0];
    c_m  = c_s & (i_m == 7'h59);
    t8   = bcd_inc({1'b0, i_m});
    n_m  = (i_m == 7'h59) ? 7'h00 : t8[6:0];
    t8   = bcd_inc({3'b000, i_hr[4:0]});
    if (i_hr[6]) begin
      if (i_hr[4:0] == 5'h11) begin
        n_hr = {1'b1, ~i_hr[5], 5'h12};
        c_hr = i_hr[5];
      end else if (i_hr[4:0] == 5'h12) begin
        n_hr = {1'b1, i_hr[5], 5'h01};
        c_hr = 1'b0;
      end else begin
        n_hr = {1'b1, i_hr[5], t8[4:0]};
        c_hr = 1'b0;
      end
    end else if (i_hr[5:0] == 6'h23) begin
      n_hr = 7'h00;
      c_hr = 1'b1;
    end else begin
      t8   = bcd_inc({2'b00, i_hr[5:0]});
      n_hr = {1'b0, t8[5:0]};
      c_hr = 1'b0;
    end
    n_dw   = (i_dw == 3'd7) ? 3'd1 : i_dw + 3'd1;
    yr_bin = {i_yr[7:4], 3'b000} + {3'b000, i_yr[7:4], 1'b0} + {4'h0, i_yr[3:0]};
    leap   = (yr_bin[1:0] == 2'b00);
    case (i_mo)
      5'h02:                      dim = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dim = 6'h30;
      default:                    dim = 6'h31;
    endcase
    c_dt = (i_dt == dim);
    t8   = bcd_inc({2'b00, i_dt});
    n_dt = c_dt ? 6'h01 : t8[5:0];
    c_mo = (i_mo == 5'h12);
    t8   = bcd_inc({3'b000, i_mo});
    n_mo = c_mo ? 5'h01 : t8[4:0];
    n_yr = (i_yr == 8'h99) ? 8'h00 : bcd_inc(i_yr);
  end

  logic step, day_step;
  assign step     = run & pre;
  assign day_step = step & c_m & c_hr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_h <= '0; i_s <= '0; i_m <= '0; i_hr <= '0;
      i_dw <= 3'd1; i_dt <= 6'h01; i_mo <= 5'h01; i_yr <= '0;
      u_h <= '0; u_s <= '0; u_m <= '0; u_hr <= '0;
      u_dw <= 3'd1; u_dt <= 6'h01; u_mo <= 5'h01; u_yr <= '0;
      te <= 1'b1; osc_stop <= 1'b1; sqw_dis <= 1'b1; sqw_q <= 1'b0;
      dirty <= '0;
    end else if (load) begin
      te <= 1'b1;
      dirty <= '0;
      if (dirty[0]) i_h  <= u_h;
      if (dirty[1]) i_s  <= u_s;
      if (dirty[2]) i_m  <= u_m;
      if (dirty[3]) i_hr <= u_hr;
      if (dirty[4]) i_dw <= u_dw;
      if (dirty[5]) i_dt <= u_dt;
      if (dirty[6]) i_mo <= u_mo;
      if (dirty[7]) i_yr <= u_yr;
    end else begin
      if (tick_2048hz && !osc_stop) sqw_q <= ~sqw_q;
      if (run) i_h <= n_h;
      if (step) i_s <= n_s;
      if (step && c_s) i_m <= n_m;
      if (step && c_m) i_hr <= n_hr;
      if (day_step) begin
        i_dw <= n_dw;
        i_dt <= n_dt;
      end
      if (day_step && c_dt) i_mo <= n_mo;
      if (day_step && c_dt && c_mo) i_yr <= n_yr;
      if (run && te) begin
        u_h <= n_h;
        if (roll) begin
          u_s <= i_s; u_m <= i_m; u_hr <= i_hr; u_dw <= i_dw;
          u_dt <= i_dt; u_mo <= i_mo; u_yr <= i_yr;
        end
      end
      if (wr_en) begin
        case (addr)
          A_HUN: begin u_h  <= wr_data;      if (wt) i_h  <= wr_data;      else dirty[0] <= 1'b1; end
          A_SEC: begin u_s  <= wr_data[6:0]; if (wt) i_s  <= wr_data[6:0]; else dirty[1] <= 1'b1; end
          A_MIN: begin u_m  <= wr_data[6:0]; if (wt) i_m  <= wr_data[6:0]; else dirty[2] <= 1'b1; end
          A_HR:  begin u_hr <= wr_data[6:0]; if (wt) i_hr <= wr_data[6:0]; else dirty[3] <= 1'b1; end
          A_DOW: begin u_dw <= wr_data[2:0]; if (wt) i_dw <= wr_data[2:0]; else dirty[4] <= 1'b1; end
          A_DAT: begin u_dt <= wr_data[5:0]; if (wt) i_dt <= wr_data[5:0]; else dirty[5] <= 1'b1; end
          A_MON: begin
            u_mo <= wr_data[4:0];
            osc_stop <= wr_data[7];
            sqw_dis  <= wr_data[6];
            if (wt) i_mo <= wr_data[4:0]; else dirty[6] <= 1'b1;
          end
          A_YR:  begin u_yr <= wr_data;      if (wt) i_yr <= wr_data;      else dirty[7] <= 1'b1; end
          A_CTL: te <= wr_data[7];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_HUN:   rd_data = u_h;
      A_SEC:   rd_data = {1'b0, u_s};
      A_MIN:   rd_data = {1'b0, u_m};
      A_HR:    rd_data = {1'b0, u_hr};
      A_DOW:   rd_data = {5'b0, u_dw};
      A_DAT:   rd_data = {2'b0, u_dt};
      A_MON:   rd_data = {osc_stop, sqw_dis, 1'b0, u_mo};
      A_YR:    rd_data = u_yr;
      A_CTL:   rd_data = {te, 7'b0};
      default: rd_data = 8'h00;
    endcase
  end

  assign sqw_oe  = ~sqw_dis;
  assign sqw_out = sqw_q & ~sqw_dis;

  // R1: internal hundredths wrap from 99 to 00
  a_r1_hund_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && roll && !wr_en) |=> (i_h == 8'h00));
  // R5: visible seconds hold except at the rollover tick
  a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!roll && !wr_en) |=> $stable(u_s) && $stable(u_m) && $stable(u_dt));
  // R6: frozen view does not move
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !wr_en) |=> $stable(u_h) && $stable(u_s) && $stable(u_hr));
  // R8: stopped oscillator holds time and square wave
  a_r8_osc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !wr_en) |=> $stable(i_h) && $stable(i_s) && $stable(sqw_q));
  // R9: running square wave toggles on each 2048 Hz tick
  a_r9_sqw_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_2048hz && !osc_stop && !load) |=> (sqw_q != $past(sqw_q)));
endmodule

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, t100 = 1'b0, t2k = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic sqw_out, sqw_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_rtc_core dut_i (.clk(clk), .rst_n(rst_n), .tick_100hz(t100), .tick_2048hz(t2k),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .sqw_out(sqw_out), .sqw_oe(sqw_oe));

  // {hour, dow, date, month, year, exp hour, exp dow, exp date, exp month, exp year}
  localparam logic [79:0] VEC [12] = '{
    {8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00},
    {8'h23, 8'h03, 8'h30, 8'h04, 8'h21, 8'h00, 8'h04, 8'h01, 8'h05, 8'h21},
    {8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23},
    {8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24},
    {8'h23, 8'h05, 8'h29, 8'h02, 8'h00, 8'h00, 8'h06, 8'h01, 8'h03, 8'h00},
    {8'h09, 8'h01, 8'h15, 8'h06, 8'h10, 8'h10, 8'h01, 8'h15, 8'h06, 8'h10},
    {8'h19, 8'h01, 8'h15, 8'h06, 8'h10, 8'h20, 8'h01, 8'h15, 8'h06, 8'h10},
    {8'h51, 8'h02, 8'h10, 8'h07, 8'h05, 8'h72, 8'h02, 8'h10, 8'h07, 8'h05},
    {8'h71, 8'h04, 8'h31, 8'h07, 8'h05, 8'h52, 8'h05, 8'h01, 8'h08, 8'h05},
    {8'h72, 8'h04, 8'h31, 8'h07, 8'h05, 8'h61, 8'h04, 8'h31, 8'h07, 8'h05},
    {8'h23, 8'h06, 8'h30, 8'h09, 8'h41, 8'h00, 8'h07, 8'h01, 8'h10, 8'h41},
    {8'h23, 8'h01, 8'h28, 8'h02, 8'h98, 8'h00, 8'h02, 8'h01, 8'h03, 8'h98}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t100 = 1'b1;
      @(negedge clk); t100 = 1'b0;
    end
  endtask

  task automatic sq_tick();
    @(negedge clk); t2k = 1'b1;
    @(negedge clk); t2k = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset values
    rd(4'h0, v); chk("R11 hund", v, 8'h00);
    rd(4'h1, v); chk("R11 sec", v, 8'h00);
    rd(4'h2, v); chk("R11 min", v, 8'h00);
    rd(4'h4, v); chk("R11 hour", v, 8'h00);
    rd(4'h6, v); chk("R11 dow", v, 8'h01);
    rd(4'h8, v); chk("R11 date", v, 8'h01);
    rd(4'h9, v); chk("R11 month", v, 8'hC1);
    rd(4'hA, v); chk("R11 year", v, 8'h00);
    rd(4'hB, v); chk("R11 ctl", v, 8'h80);
    chk("R11 sqw_oe", {7'b0, sqw_oe}, 8'h00);
    // R8 oscillator stopped after reset
    tick(3);
    rd(4'h0, v); chk("R8 stopped hund", v, 8'h00);
    // R10 masking and unmapped addresses
    wr(4'h1, 8'hFF); rd(4'h1, v); chk("R10 sec mask", v, 8'h7F);
    wr(4'h6, 8'hFF); rd(4'h6, v); chk("R10 dow mask", v, 8'h07);
    wr(4'h8, 8'hFF); rd(4'h8, v); chk("R10 date mask", v, 8'h3F);
    wr(4'h3, 8'hFF); rd(4'h3, v); chk("R10 unmapped", v, 8'h00);
    wr(4'hB, 8'hFF); rd(4'hB, v); chk("R10 ctl mask", v, 8'h80);

    // table walk: R1 R2 R3 R4 R5
    foreach (VEC[k]) begin
      wr(4'h4, VEC[k][79:72]); wr(4'h6, VEC[k][71:64]); wr(4'h8, VEC[k][63:56]);
      wr(4'h9, 8'h40 | VEC[k][55:48]); wr(4'hA, VEC[k][47:40]);
      wr(4'h2, 8'h59); wr(4'h1, 8'h59); wr(4'h0, 8'h98);
      tick(1);
      rd(4'h0, v); chk("R1 hund 99", v, 8'h99);
      rd(4'h1, v); chk("R5 sec held", v, 8'h59);
      rd(4'h4, v); chk("R5 hour held", v, VEC[k][79:72]);
      tick(1);
      rd(4'h0, v); chk("R1 hund wrap", v, 8'h00);
      rd(4'h1, v); chk("R1 sec wrap", v, 8'h00);
      rd(4'h2, v); chk("R1 min wrap", v, 8'h00);
      rd(4'h4, v); chk("R2 R3 hour", v, VEC[k][39:32]);
      rd(4'h6, v); chk("R4 dow", v, VEC[k][31:24]);
      rd(4'h8, v); chk("R4 date", v, VEC[k][23:16]);
      rd(4'h9, v); chk("R4 month", v & 8'h1F, VEC[k][15:8]);
      rd(4'hA, v); chk("R4 year", v, VEC[k][7:0]);
    end

    // R9 square wave gate and toggle
    chk("R9 disabled oe", {7'b0, sqw_oe}, 8'h00);
    chk("R9 disabled out", {7'b0, sqw_out}, 8'h00);
    wr(4'h9, 8'h01);
    chk("R9 enabled oe", {7'b0, sqw_oe}, 8'h01);
    s0 = sqw_out;
    sq_tick(); chk("R9 toggle 1", {7'b0, sqw_out}, {7'b0, ~s0});
    sq_tick(); chk("R9 toggle 2", {7'b0, sqw_out}, {7'b0, s0});
    wr(4'h9, 8'h81);
    sq_tick(); chk("R8 sqw held", {7'b0, sqw_out}, {7'b0, s0});
    wr(4'h9, 8'h41);
    chk("R9 off out", {7'b0, sqw_out}, 8'h00);

    // R6 freeze keeps internal time
    wr(4'h2, 8'h00); wr(4'h1, 8'h00); wr(4'h0, 8'h00);
    tick(50);
    rd(4'h0, v); chk("R5 hund per tick", v, 8'h50);
    wr(4'hB, 8'h00);
    tick(200);
    rd(4'h0, v); chk("R6 frozen hund", v, 8'h50);
    rd(4'h1, v); chk("R6 frozen sec", v, 8'h00);
    wr(4'hB, 8'h80);
    tick(1);
    rd(4'h0, v); chk("R6 resume hund", v, 8'h51);
    rd(4'h1, v); chk("R6 sec stale until roll", v, 8'h00);
    tick(49);
    rd(4'h0, v); chk("R6 caught hund", v, 8'h00);
    rd(4'h1, v); chk("R6 caught sec", v, 8'h03);

    // R7 write during freeze loaded at release
    wr(4'hB, 8'h00);
    tick(100);
    wr(4'h2, 8'h30);
    rd(4'h2, v); chk("R7 visible write", v, 8'h30);
    rd(4'h1, v); chk("R7 sec still frozen", v, 8'h03);
    wr(4'hB, 8'h80);
    tick(100);
    rd(4'h0, v); chk("R7 hund", v, 8'h00);
    rd(4'h1, v); chk("R7 unwritten sec kept running", v, 8'h05);
    rd(4'h2, v); chk("R7 min loaded", v, 8'h30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule